// File: doc/BRIEF.md
# Speculative Miss Latency Filter

This block sits beside a core's L1 data cache while speculative threads run. It measures how long each data miss takes to be served. It then decides whether a purely sequential run on one core would have paid that same latency. Only latency that a sequential run would also see goes into a running data-stall total. A profiling layer reads that total later to judge whether speculative threads help or hurt a loop.

Some misses are not charged. A miss that hit a tag whose line had been invalidated by speculative activity is a coherence miss, and a sequential run would not have it. A line that arrives in shared state is already counted by another core, so charging it here would count it twice. Some evictions are charged a fixed penalty instead: when the evicted line had been loaded and shared by a logically later thread, a sequential run would refetch it from L2, and the penalty stands for that refetch.

The total survives thread squashes. Only the spawn-time clear resets it.

Top module: `miss_cost_filter`

## Requirements
- R1: After reset, `dcache_total` and `serve_cnt` are both 0.
- R2: A miss is tracked only while none is in flight. The edge that accepts `miss_start` sets `serve_cnt` to 1. Every later edge while the miss is in flight adds 1 to `serve_cnt`. The edge that accepts `miss_done` returns `serve_cnt` to 0.
- R3: On the edge that accepts `miss_done`, the value `serve_cnt` held just before that edge (N, the number of edges from start to done) is added to `dcache_total`. This applies when `miss_tag_inv` was 0 at the start edge and `fill_shared` is 0 at the done edge.
- R4: If `miss_tag_inv` was 1 on the start edge, the completed miss adds nothing.
- R5: If `fill_shared` is 1 on the done edge, the completed miss adds nothing.
- R6: An edge with `evict_v`=1 and `evict_later_shared`=1 adds PENALTY (default 18) to `dcache_total`. An edge with `evict_v`=1 and `evict_later_shared`=0 adds nothing.
- R7: `squash` has no effect on `dcache_total` or on `serve_cnt`.
- R8: A `miss_start` while a miss is in flight is ignored. `serve_cnt` keeps counting.
- R9: An eviction penalty and a completed-miss addition on the same edge are both applied.
- R10: `dcache_total` saturates at its all-ones value (2^CNT_W-1) and never wraps.
- R11: `spawn_clr` clears `dcache_total` and `serve_cnt` and abandons any in-flight miss. It takes priority over every other input.
- R12: A `miss_done` with no miss in flight adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spawn_clr | input | 1 | Thread spawned on this core; clears the counters |
| miss_start | input | 1 | L1 data miss begins |
| miss_tag_inv | input | 1 | Miss address matched a tag in invalid state (valid with miss_start) |
| miss_done | input | 1 | Miss has been serviced |
| fill_shared | input | 1 | Filled line arrived in shared state (valid with miss_done) |
| evict_v | input | 1 | A line is being evicted |
| evict_later_shared | input | 1 | Evicted line was loaded and shared by a logically later thread |
| squash | input | 1 | Current thread is squashed |
| dcache_total | output | CNT_W | Accumulated data-stall cycles |
| serve_cnt | output | SERVE_W | Cycles of the miss currently in flight |

## Verification
Every result is registered, so each strobe shows up at the outputs exactly one clock edge after the edge that samples it. `serve_cnt` reads 1 right after the start edge and N right before the done edge. The miss addition and any penalty appear in `dcache_total` right after the done or eviction edge. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. Its expected totals come from a running sum, clipped at the saturation value, built from the requirement arithmetic. The bench uses a 10-bit total so that the saturation case can be reached.

// File: rtl/miss_cost_filter.sv
module miss_cost_filter #(
  parameter int CNT_W   = 32,
  parameter int SERVE_W = 16,
  parameter int PENALTY = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spawn_clr,
  input  logic               miss_start,
  input  logic               miss_tag_inv,
  input  logic               miss_done,
  input  logic               fill_shared,
  input  logic               evict_v,
  input  logic               evict_later_shared,
  input  logic               squash,
  output logic [CNT_W-1:0]   dcache_total,
  output logic [SERVE_W-1:0] serve_cnt
);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [CNT_W-1:0]   CNT_MAX   = '1;
  localparam logic [SERVE_W-1:0] SERVE_MAX = '1;

  logic busy, inv_q;

  wire take_start = miss_start && !busy;
  wire finish     = miss_done && busy;
  wire counted    = finish && !inv_q && !fill_shared;

  wire [SUM_W-1:0] miss_add = counted ? SUM_W'(serve_cnt) : '0;
  wire [SUM_W-1:0] pen_add  = (evict_v && evict_later_shared) ? SUM_W'(PENALTY) : '0;
  wire [SUM_W-1:0] sum      = SUM_W'(dcache_total) + miss_add + pen_add;
  wire [CNT_W-1:0] next_total = (sum > SUM_W'(CNT_MAX)) ? CNT_MAX : sum[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      inv_q     <= 1'b0;
      serve_cnt <= '0;
    end else if (spawn_clr) begin
      busy      <= 1'b0;
      inv_q     <= 1'b0;
      serve_cnt <= '0;
    end else if (finish) begin
      busy      <= 1'b0;
      serve_cnt <= '0;
    end else if (take_start) begin
      busy      <= 1'b1;
      inv_q     <= miss_tag_inv;
      serve_cnt <= SERVE_W'(1);
    end else if (busy && serve_cnt != SERVE_MAX) begin
      serve_cnt <= serve_cnt + SERVE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dcache_total <= '0;
    else if (spawn_clr) dcache_total <= '0;
    else                dcache_total <= next_total;
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_start && !busy && !spawn_clr) |=> (serve_cnt == SERVE_W'(1)));

  p_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_done && busy) |=> (serve_cnt == '0));

  p_squash_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (squash && !spawn_clr) |=> (dcache_total >= $past(dcache_total)));

  p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dcache_total == CNT_MAX && !spawn_clr) |=> (dcache_total == CNT_MAX));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    spawn_clr |=> (dcache_total == '0 && serve_cnt == '0));
endmodule

// File: tb/miss_cost_filter_tb.sv
`timescale 1ns/1ps
module miss_cost_filter_tb;
  localparam int CW = 10;
  localparam int SW = 16;
  localparam int PEN = 18;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic spawn_clr = 0, miss_start = 0, miss_tag_inv = 0, miss_done = 0;
  logic fill_shared = 0, evict_v = 0, evict_later_shared = 0, squash = 0;
  logic [CW-1:0] dcache_total;
  logic [SW-1:0] serve_cnt;

  int errors = 0, checks = 0, exp_d = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  miss_cost_filter #(.CNT_W(CW), .SERVE_W(SW), .PENALTY(PEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .spawn_clr(spawn_clr), .miss_start(miss_start),
    .miss_tag_inv(miss_tag_inv), .miss_done(miss_done), .fill_shared(fill_shared),
    .evict_v(evict_v), .evict_later_shared(evict_later_shared), .squash(squash),
    .dcache_total(dcache_total), .serve_cnt(serve_cnt));

  function automatic int sat(int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start_miss(bit inv);
    miss_start = 1; miss_tag_inv = inv;
    step;
    miss_start = 0; miss_tag_inv = 0;
    chk("R2 serve after start", serve_cnt, 1);
  endtask

  task automatic end_miss(int n, bit inv, bit shr, bit ev, string req);
    miss_done = 1; fill_shared = shr; evict_v = ev; evict_later_shared = ev;
    step;
    miss_done = 0; fill_shared = 0; evict_v = 0; evict_later_shared = 0;
    exp_d = sat(exp_d + ((inv || shr) ? 0 : n) + (ev ? PEN : 0));
    chk(req, dcache_total, exp_d);
    chk("R2 serve after done", serve_cnt, 0);
  endtask

  task automatic evict(bit later);
    evict_v = 1; evict_later_shared = later;
    step;
    evict_v = 0; evict_later_shared = 0;
    exp_d = sat(exp_d + (later ? PEN : 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset total", dcache_total, 0);
    chk("R1 reset serve", serve_cnt, 0);
    rst_n = 1;
    step;

    // R3 R4 R5 sweep over latency and the two exclusion flags
    for (int n = 1; n <= 5; n++)
      for (int c = 0; c < 4; c++) begin
        start_miss(c[0]);
        repeat (n - 1) step;
        chk("R2 serve before done", serve_cnt, n);
        end_miss(n, c[0], c[1], 0, c[0] ? "R4 invalid-tag miss" :
                                   (c[1] ? "R5 shared fill" : "R3 clean miss"));
      end

    // R6
    evict(1); chk("R6 penalty eviction", dcache_total, exp_d);
    evict(0); chk("R6 plain eviction", dcache_total, exp_d);

    // R9
    start_miss(0); repeat (3) step;
    end_miss(4, 0, 0, 1, "R9 miss plus penalty");

    // R8
    start_miss(0); step;
    miss_start = 1; step; miss_start = 0;
    chk("R8 restart ignored", serve_cnt, 3);
    end_miss(3, 0, 0, 0, "R8 total");

    // R7
    start_miss(0);
    squash = 1; step; squash = 0;
    chk("R7 serve through squash", serve_cnt, 2);
    chk("R7 total through squash", dcache_total, exp_d);
    end_miss(2, 0, 0, 0, "R7 miss after squash");
    squash = 1; step; squash = 0;
    chk("R7 idle squash", dcache_total, exp_d);

    // R12
    miss_done = 1; step; miss_done = 0;
    chk("R12 stray done", dcache_total, exp_d);
    chk("R12 stray done serve", serve_cnt, 0);

    // R10
    for (int i = 0; i < 60; i++) begin
      evict(1);
      chk("R10 saturation", dcache_total, exp_d);
    end
    start_miss(0); step;
    end_miss(2, 0, 0, 0, "R10 saturated miss");

    // R11
    start_miss(0); step;
    spawn_clr = 1; miss_done = 1; evict_v = 1; evict_later_shared = 1;
    step;
    spawn_clr = 0; miss_done = 0; evict_v = 0; evict_later_shared = 0;
    exp_d = 0;
    chk("R11 clear total", dcache_total, 0);
    chk("R11 clear serve", serve_cnt, 0);
    miss_done = 1; step; miss_done = 0;
    chk("R11 abandoned miss", dcache_total, 0);
    start_miss(0); repeat (2) step;
    end_miss(3, 0, 0, 0, "R11 miss after clear");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule